// File: doc/BRIEF.md
# Frame Interrupt and Late-Token Cancel Controller

This block sits beside the frame generator of a bus host controller. Each time the hardware sends a start-of-frame packet, it decides whether to raise the frame interrupt flag. In step mode it raises the flag on every frame. Otherwise it raises the flag only when the low eight bits of the current frame number equal a compare value held by software. A start-of-frame that software issues through the token register never raises the flag. The flag drives an interrupt line through an enable bit.

The block also watches token writes. A SETUP, IN or OUT token that software posts while the end-of-frame window is open is held as late until the next hardware start-of-frame. At that point there are two outcomes:
- If cancelling is enabled and the frame interrupt flag is set, the token is dropped. The block pulses a request to clear the token code to zero and sets a sticky cancel flag. It never launches the token, so the token never reports completion.
- In every other case the block pulses a launch request, and the token goes out right after the frame.

Both flags are sticky. A software write of 0 clears a flag, and a write of 1 leaves it unchanged.

Top module: `frame_irq_ctrl`

## Requirements
- R1: With step_mode=1, every hardware start-of-frame (sof_sent=1, sof_by_sw=0) sets sof_flag on the following clock edge, whatever the frame number is.
- R2: With step_mode=0, a hardware start-of-frame sets sof_flag only when frame_num[7:0] equals frame_cmp. On a mismatch sof_flag stays 0.
- R3: A start-of-frame with sof_by_sw=1 never sets sof_flag, in either mode.
- R4: sof_irq is 1 exactly when sof_flag=1 and sof_irq_en=1.
- R5: A token write (tok_wr=1) with a code of 001 (SETUP), 010 (IN) or 011 (OUT), made while eof_window=1, is held as late. At the next hardware start-of-frame, if cancel_en=1 and sof_flag is either already set or set by that frame, the block does three things one cycle after the frame strobe: it pulses tok_clear for one cycle, it sets tcan_flag, and it does not pulse tok_launch.
- R6: With cancel_en=0 at that frame, a late token instead produces a one-cycle tok_launch pulse one cycle after the frame strobe. It produces no tok_clear, and tcan_flag stays 0.
- R7: With cancel_en=1 but sof_flag neither set nor set by that frame, a late token is launched as in R6.
- R8: A token written with eof_window=0, or with code 100 (SOF) or 000, is not held. The next start-of-frame produces neither tok_clear nor tok_launch.
- R9: A software write (sw_wr=1) writes sw_sof_bit into sof_flag and sw_tcan_bit into tcan_flag. A bit value of 0 clears the flag, and a bit value of 1 leaves the flag as it was.
- R10: After reset sof_flag, tcan_flag, sof_irq, tok_clear and tok_launch are all 0.
- R11: When a set condition and a clearing write reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_sent | input | 1 | One-cycle strobe when a start-of-frame packet is sent |
| sof_by_sw | input | 1 | Qualifies sof_sent: the frame was issued by software through the token register |
| frame_num | input | 11 | Current frame number |
| frame_cmp | input | 8 | Compare value for the low frame byte |
| step_mode | input | 1 | 1: flag on every frame; 0: flag on compare match |
| cancel_en | input | 1 | Enables dropping of late tokens |
| eof_window | input | 1 | End-of-frame window is open |
| tok_wr | input | 1 | Software token write strobe |
| tok_code | input | 3 | Token code written with tok_wr |
| sw_wr | input | 1 | Software write strobe to the flags |
| sw_sof_bit | input | 1 | Write data for sof_flag |
| sw_tcan_bit | input | 1 | Write data for tcan_flag |
| sof_irq_en | input | 1 | Frame interrupt enable |
| sof_flag | output | 1 | Sticky frame interrupt flag |
| tcan_flag | output | 1 | Sticky token-cancelled flag |
| tok_clear | output | 1 | One-cycle request to clear the pending token code to 000 |
| tok_launch | output | 1 | One-cycle request to send the held token after the frame |
| sof_irq | output | 1 | Gated interrupt line |

## Verification
The bench targets several corner cases, and each one exposes a specific kind of fault:

- **Compare on the low byte only.** The bench uses frame numbers whose upper three bits differ but whose low byte matches. A design that compares all eleven bits would miss the match.
- **Late token against an already-set flag.** The bench posts a late token while the flag is already set and the next frame does not match. A design that looks only at the current frame's match would launch the token instead of cancelling it.
- **Excluded token codes.** The bench writes an SOF code and a token outside the window. A design that latches every write would issue a stray launch.
- **Writes of 1 and write-versus-set collisions.** A design that treats the write as plain data would set a flag on a write of 1. A design that gives the write priority would lose an interrupt.

// File: rtl/frame_irq_pkg.sv
package frame_irq_pkg;
   localparam int TOK_W = 3;
   typedef enum logic [TOK_W-1:0] {
      TK_NONE  = 3'b000,
      TK_SETUP = 3'b001,
      TK_IN    = 3'b010,
      TK_OUT   = 3'b011,
      TK_SOF   = 3'b100
   } tok_code_e;

   function automatic logic is_xfer_token(input logic [TOK_W-1:0] c);
      return (c == TK_SETUP) || (c == TK_IN) || (c == TK_OUT);
   endfunction
endpackage

// File: rtl/frame_match.sv
module frame_match #(
   parameter int FRAME_W = 11,
   parameter int CMP_W   = 8
) (
   input  logic [FRAME_W-1:0] frame_num,
   input  logic [CMP_W-1:0]   frame_cmp,
   input  logic               step_mode,
   output logic               hit
);
   initial begin
      if (CMP_W < 1 || CMP_W > FRAME_W)
         $error("frame_match: CMP_W must be in 1..FRAME_W");
   end

   logic [CMP_W-1:0] bit_eq;
   genvar gi;
   generate
      for (gi = 0; gi < CMP_W; gi++) begin : g_cmp
         assign bit_eq[gi] = ~(frame_num[gi] ^ frame_cmp[gi]);
      end
   endgenerate

   assign hit = step_mode | (&bit_eq);
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic wr_i,
   input  logic wdata_i,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (set_i)  q <= 1'b1;
      else if (wr_i)   q <= q & wdata_i;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q); // R11
   AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && wr_i && wdata_i) |=> (q == $past(q))); // R9
   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!q && !set_i) |=> !q); // R3
endmodule

// File: rtl/late_token.sv
module late_token
   import frame_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tok_wr,
   input  logic [TOK_W-1:0] tok_code,
   input  logic             eof_window,
   input  logic             hw_sof,
   input  logic             cancel_en,
   input  logic             flag_at_sof,
   output logic             drop_now,
   output logic             tok_clear,
   output logic             tok_launch
);
   logic held;
   logic capture;

   assign capture  = tok_wr && eof_window && is_xfer_token(tok_code);
   assign drop_now = held && hw_sof && cancel_en && flag_at_sof;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held       <= 1'b0;
         tok_clear  <= 1'b0;
         tok_launch <= 1'b0;
      end else begin
         tok_clear  <= drop_now;
         tok_launch <= held && hw_sof && !drop_now;
         if (hw_sof)       held <= capture;
         else if (capture) held <= 1'b1;
      end
   end

   AST_CLEAR_LAUNCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(tok_clear && tok_launch)); // R5
   AST_NOTHING_UNHELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!held && hw_sof) |=> (!tok_clear && !tok_launch)); // R8
   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      tok_launch |=> !tok_launch); // R6
endmodule

// File: rtl/frame_irq_ctrl.sv
module frame_irq_ctrl
   import frame_irq_pkg::*;
#(
   parameter int FRAME_W = 11,
   parameter int CMP_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sof_sent,
   input  logic               sof_by_sw,
   input  logic [FRAME_W-1:0] frame_num,
   input  logic [CMP_W-1:0]   frame_cmp,
   input  logic               step_mode,
   input  logic               cancel_en,
   input  logic               eof_window,
   input  logic               tok_wr,
   input  logic [TOK_W-1:0]   tok_code,
   input  logic               sw_wr,
   input  logic               sw_sof_bit,
   input  logic               sw_tcan_bit,
   input  logic               sof_irq_en,
   output logic               sof_flag,
   output logic               tcan_flag,
   output logic               tok_clear,
   output logic               tok_launch,
   output logic               sof_irq
);
   logic hw_sof;
   logic hit;
   logic sof_set;
   logic drop_now;

   assign hw_sof = sof_sent && !sof_by_sw;

   frame_match #(.FRAME_W(FRAME_W), .CMP_W(CMP_W)) u_match (
      .frame_num(frame_num), .frame_cmp(frame_cmp),
      .step_mode(step_mode), .hit(hit));

   assign sof_set = hw_sof && hit;

   sticky_flag u_sof_flag (
      .clk(clk), .rst_n(rst_n), .set_i(sof_set),
      .wr_i(sw_wr), .wdata_i(sw_sof_bit), .q(sof_flag));

   late_token u_late (
      .clk(clk), .rst_n(rst_n), .tok_wr(tok_wr), .tok_code(tok_code),
      .eof_window(eof_window), .hw_sof(hw_sof), .cancel_en(cancel_en),
      .flag_at_sof(sof_flag | sof_set), .drop_now(drop_now),
      .tok_clear(tok_clear), .tok_launch(tok_launch));

   sticky_flag u_tcan_flag (
      .clk(clk), .rst_n(rst_n), .set_i(drop_now),
      .wr_i(sw_wr), .wdata_i(sw_tcan_bit), .q(tcan_flag));

   assign sof_irq = sof_flag & sof_irq_en;

   AST_STEP_EVERY_SOF: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_sof && step_mode) |=> sof_flag); // R1
   AST_LOW_BYTE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_sof && frame_num[CMP_W-1:0] == frame_cmp) |=> sof_flag); // R2
   AST_SW_SOF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!sof_flag && sof_sent && sof_by_sw) |=> !sof_flag); // R3
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      sof_irq |-> (sof_flag && sof_irq_en)); // R4
   AST_CLEAR_SETS_TCAN: assert property (@(posedge clk) disable iff (!rst_n)
      tok_clear |-> tcan_flag); // R5
endmodule

// File: tb/frame_irq_ctrl_tb.sv
module frame_irq_ctrl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sof_sent = 0, sof_by_sw = 0;
   logic [10:0] frame_num = '0;
   logic [7:0]  frame_cmp = '0;
   logic step_mode = 0, cancel_en = 0, eof_window = 0, tok_wr = 0;
   logic [2:0] tok_code = '0;
   logic sw_wr = 0, sw_sof_bit = 1, sw_tcan_bit = 1, sof_irq_en = 0;
   logic sof_flag, tcan_flag, tok_clear, tok_launch, sof_irq;
   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   frame_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .sof_sent(sof_sent), .sof_by_sw(sof_by_sw),
      .frame_num(frame_num), .frame_cmp(frame_cmp), .step_mode(step_mode),
      .cancel_en(cancel_en), .eof_window(eof_window), .tok_wr(tok_wr),
      .tok_code(tok_code), .sw_wr(sw_wr), .sw_sof_bit(sw_sof_bit),
      .sw_tcan_bit(sw_tcan_bit), .sof_irq_en(sof_irq_en), .sof_flag(sof_flag),
      .tcan_flag(tcan_flag), .tok_clear(tok_clear), .tok_launch(tok_launch),
      .sof_irq(sof_irq));

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic frame(input logic hw, input logic [10:0] fn);
      sof_sent = 1; sof_by_sw = !hw; frame_num = fn;
      tick();
      sof_sent = 0; sof_by_sw = 0;
   endtask

   task automatic post_token(input logic [2:0] code, input logic win);
      tok_wr = 1; tok_code = code; eof_window = win;
      tick();
      tok_wr = 0; eof_window = 0;
   endtask

   task automatic sw_write(input logic s, input logic t);
      sw_wr = 1; sw_sof_bit = s; sw_tcan_bit = t;
      tick();
      sw_wr = 0; sw_sof_bit = 1; sw_tcan_bit = 1;
   endtask

   task automatic t_reset();
      chk("R10 sof_flag", sof_flag, 0);
      chk("R10 tcan_flag", tcan_flag, 0);
      chk("R10 tok_clear", tok_clear, 0);
      chk("R10 tok_launch", tok_launch, 0);
      chk("R10 sof_irq", sof_irq, 0);
   endtask

   task automatic t_step();
      step_mode = 1; frame_cmp = 8'h55;
      frame(1, 11'h123);
      chk("R1 step set", sof_flag, 1);
      sw_write(0, 1);
      chk("R9 clear by 0", sof_flag, 0);
      frame(1, 11'h7FE);
      chk("R1 step again", sof_flag, 1);
      sw_write(0, 1);
      step_mode = 0;
   endtask

   task automatic t_match();
      frame_cmp = 8'h11;
      frame(1, 11'h010);
      chk("R2 mismatch", sof_flag, 0);
      frame(1, 11'h511);
      chk("R2 low byte match", sof_flag, 1);
      sof_irq_en = 0;
      #1 chk("R4 gated off", sof_irq, 0);
      sof_irq_en = 1;
      #1 chk("R4 enabled", sof_irq, 1);
      sw_write(1, 1);
      chk("R9 write 1 keeps", sof_flag, 1);
      sw_write(0, 1);
      chk("R9 cleared", sof_flag, 0);
      chk("R4 irq drops", sof_irq, 0);
   endtask

   task automatic t_sw_sof();
      step_mode = 1;
      frame(0, 11'h011);
      chk("R3 sw frame step", sof_flag, 0);
      step_mode = 0; frame_cmp = 8'h11;
      frame(0, 11'h011);
      chk("R3 sw frame match", sof_flag, 0);
   endtask

   task automatic t_cancel();
      cancel_en = 1; frame_cmp = 8'h20;
      post_token(3'b010, 1);
      sof_sent = 1; frame_num = 11'h020;
      tick();
      sof_sent = 0;
      chk("R5 clear pulse", tok_clear, 1);
      chk("R5 no launch", tok_launch, 0);
      chk("R5 tcan set", tcan_flag, 1);
      chk("R5 flag set", sof_flag, 1);
      tick();
      chk("R5 pulse one cycle", tok_clear, 0);
      post_token(3'b001, 1);
      frame(1, 11'h021);
      chk("R5 old flag cancels", tok_clear, 1);
      chk("R5 old flag no launch", tok_launch, 0);
      sw_write(0, 0);
      chk("R9 tcan cleared", tcan_flag, 0);
   endtask

   task automatic t_launch();
      cancel_en = 0; frame_cmp = 8'h30;
      post_token(3'b011, 1);
      frame(1, 11'h030);
      chk("R6 launch", tok_launch, 1);
      chk("R6 no clear", tok_clear, 0);
      chk("R6 tcan stays", tcan_flag, 0);
      tick();
      chk("R6 pulse one cycle", tok_launch, 0);
      sw_write(0, 1);
      cancel_en = 1;
      post_token(3'b010, 1);
      frame(1, 11'h031);
      chk("R7 launch no flag", tok_launch, 1);
      chk("R7 no clear", tok_clear, 0);
      chk("R7 tcan stays", tcan_flag, 0);
   endtask

   task automatic t_ignored();
      cancel_en = 1; step_mode = 1;
      post_token(3'b010, 0);
      frame(1, 11'h040);
      chk("R8 outside window launch", tok_launch, 0);
      chk("R8 outside window clear", tok_clear, 0);
      post_token(3'b100, 1);
      frame(1, 11'h041);
      chk("R8 sof code launch", tok_launch, 0);
      chk("R8 sof code clear", tok_clear, 0);
      chk("R8 tcan untouched", tcan_flag, 0);
      sw_write(0, 0);
      step_mode = 0;
   endtask

   task automatic t_collide();
      step_mode = 1;
      sof_sent = 1; frame_num = 11'h050; sw_wr = 1; sw_sof_bit = 0;
      tick();
      sof_sent = 0; sw_wr = 0; sw_sof_bit = 1;
      chk("R11 set beats clear", sof_flag, 1);
      step_mode = 0;
      sw_write(0, 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            t_reset();
            rst_n = 1;
            tick();
            t_reset();
            t_step();
            t_match();
            t_sw_sof();
            t_cancel();
            t_launch();
            t_ignored();
            t_collide();
         end
         begin
            repeat (5000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule